// File: doc/BRIEF.md
# Read Completion Status Splitter

This block takes one inbound read request at a time and reports how it completes, as a stream of status entries. Each request carries a start byte address, a byte length and a chaining control. The request is cut at naturally aligned chunk boundaries. The chunk is 64 bytes normally and 128 bytes when chaining is on. The block emits one entry per chunk, one entry per clock, in ascending address order. Each entry carries the chunk address, its byte count, a status bit and a final-entry flag.

The start address is presented to an external target decoder on `tgt_addr`. The decoder answers on `tgt_hit` in the same cycle. When the start address decodes to a valid target, every chunk of the request reports success. When the start address does not decode, nothing is split: a single unsupported-request entry is issued for the whole length, with the address replaced by a fixed remap location in DRAM. A request of zero length, or one that runs past a 4 KB page, is also reported as a single unsupported-request entry, so that the fault is visible. The block moves no data and builds no completion packets.

Top module: `rd_cpl_splitter`

## Requirements
- R1: While reset is held and in the cycle after it is released, `ent_valid` is 0 and `req_ready` is 1.
- R2: With `req_chain`=0, a good request is reported as entries that break at every 64-byte aligned address. Each entry's address equals the previous entry's address plus its byte count.
- R3: With `req_chain`=1, a good request is reported as entries that break at every 128-byte aligned address. Each entry's address equals the previous entry's address plus its byte count.
- R4: The first and last entries are trimmed to the request's start and end. The byte counts of all entries of a request sum to its length. A request that fits inside one chunk gives one entry.
- R5: `ent_last` is 1 on the final entry of a request and on no other entry.
- R6: When `tgt_hit` is 1 in the accept cycle, every entry of the request has `ent_ur`=0 (success).
- R7: When `tgt_hit` is 0 in the accept cycle for a well-formed request, exactly one entry is issued. It has `ent_addr`=32'h000C_0000, `ent_bytes` equal to the request length, `ent_ur`=1 (unsupported request) and `ent_last`=1.
- R8: A request whose length is 0, or whose start offset within its 4 KB page plus its length exceeds 4096, gives exactly one entry. That entry has `ent_addr` equal to the request address, `ent_bytes` equal to the length, `ent_ur`=1 and `ent_last`=1. This check takes priority over R7.
- R9: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. Its first entry is valid in the following cycle, and later entries follow in consecutive cycles. `req_ready` is 0 while a non-final entry is on the outputs and 1 once the final entry is shown.
- R10: A request that ends exactly on a 4 KB boundary, including a full aligned 4096-byte page, is split normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | AW | Request start byte address |
| req_len | input | LW | Request length in bytes |
| req_chain | input | 1 | 1 selects 128-byte chunks, 0 selects 64-byte chunks |
| tgt_addr | output | AW | Address sent to the target decoder |
| tgt_hit | input | 1 | Decoder result: start address maps to a valid target |
| ent_valid | output | 1 | Status entry present |
| ent_addr | output | AW | Entry start address |
| ent_bytes | output | LW | Entry byte count |
| ent_ur | output | 1 | 1 = unsupported request, 0 = success |
| ent_last | output | 1 | Final entry of the request |

## Verification
The bench checks unaligned starts and ends in both chunk sizes. A design that mis-trims the edge chunks shows wrong byte counts and addresses that do not line up. It checks a request ending on the last byte of a page and a full 4096-byte page. An off-by-one in the page-crossing test would wrongly reject these requests. It also checks a request one chunk past the page and a zero-length request, where a missing check would emit a stream of success entries. An undecoded start is tested as well: a design that still splits it would give many entries, or none at the remap address. Back-to-back requests expose a `req_ready` released too early or too late.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  typedef enum logic {
    CPL_OK = 1'b0,
    CPL_UR = 1'b1
  } cpl_status_e;

  typedef enum logic [1:0] {
    KIND_GOOD  = 2'd0,
    KIND_SHAPE = 2'd1,
    KIND_NOTGT = 2'd2
  } req_kind_e;
endpackage

// File: rtl/rcs_req_check.sv
module rcs_req_check
  import rcs_pkg::*;
#(
  parameter int AW       = 32,
  parameter int LW       = 13,
  parameter int PAGE_LOG = 12
) (
  input  logic [AW-1:0] addr,
  input  logic [LW-1:0] len,
  input  logic          tgt_hit,
  output req_kind_e     kind
);
  localparam int SW = LW + 1;
  localparam logic [SW-1:0] PAGE_BYTES = SW'(1) << PAGE_LOG;

  logic [SW-1:0] reach;
  logic          bad_shape;

  assign reach     = SW'(addr[PAGE_LOG-1:0]) + SW'(len);
  assign bad_shape = (len == '0) || (reach > PAGE_BYTES);

  always_comb begin
    if (bad_shape)     kind = KIND_SHAPE;
    else if (!tgt_hit) kind = KIND_NOTGT;
    else               kind = KIND_GOOD;
  end
endmodule

// File: rtl/rcs_chunk_calc.sv
module rcs_chunk_calc #(
  parameter int AW        = 32,
  parameter int LW        = 13,
  parameter int CHUNK_LOG = 6
) (
  input  logic [AW-1:0] cur_addr,
  input  logic [AW:0]   end_addr,
  input  logic          chain,
  output logic [AW:0]   nxt_addr,
  output logic [LW-1:0] bytes,
  output logic          is_last
);
  localparam logic [AW:0] ONE = {{AW{1'b0}}, 1'b1};

  logic [AW:0] base;
  logic [AW:0] bnd [2];
  logic [AW:0] sel_bnd;
  logic [AW:0] diff;

  assign base = {1'b0, cur_addr};

  for (genvar g = 0; g < 2; g++) begin : g_size
    localparam int SH = CHUNK_LOG + g;
    assign bnd[g] = ((base >> SH) + ONE) << SH;
  end

  assign sel_bnd  = chain ? bnd[1] : bnd[0];
  assign is_last  = (sel_bnd >= end_addr);
  assign nxt_addr = is_last ? end_addr : sel_bnd;
  assign diff     = nxt_addr - base;
  assign bytes    = diff[LW-1:0];
endmodule

// File: rtl/rd_cpl_splitter.sv
module rd_cpl_splitter
  import rcs_pkg::*;
#(
  parameter int          AW         = 32,
  parameter int          LW         = 13,
  parameter int          CHUNK_LOG  = 6,
  parameter int          PAGE_LOG   = 12,
  parameter logic [31:0] REMAP_ADDR = 32'h000C_0000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [LW-1:0] req_len,
  input  logic          req_chain,
  output logic [AW-1:0] tgt_addr,
  input  logic          tgt_hit,
  output logic          ent_valid,
  output logic [AW-1:0] ent_addr,
  output logic [LW-1:0] ent_bytes,
  output logic          ent_ur,
  output logic          ent_last
);
  localparam logic [AW-1:0] REMAP = AW'(REMAP_ADDR);

  logic          busy;
  logic [AW-1:0] cur_q;
  logic [AW:0]   end_q;
  logic          chain_q;

  logic [AW:0]   req_end;
  req_kind_e     kind;
  logic [AW-1:0] calc_cur;
  logic [AW:0]   calc_end;
  logic          calc_chain;
  logic [AW:0]   calc_nxt;
  logic [LW-1:0] calc_bytes;
  logic          calc_last;
  logic          accept;

  assign req_ready = !busy;
  assign accept    = req_valid && !busy;
  assign tgt_addr  = req_addr;
  assign req_end   = {1'b0, req_addr} + {{(AW + 1 - LW){1'b0}}, req_len};

  rcs_req_check #(.AW(AW), .LW(LW), .PAGE_LOG(PAGE_LOG)) u_check (
    .addr    (req_addr),
    .len     (req_len),
    .tgt_hit (tgt_hit),
    .kind    (kind)
  );

  assign calc_cur   = busy ? cur_q   : req_addr;
  assign calc_end   = busy ? end_q   : req_end;
  assign calc_chain = busy ? chain_q : req_chain;

  rcs_chunk_calc #(.AW(AW), .LW(LW), .CHUNK_LOG(CHUNK_LOG)) u_calc (
    .cur_addr (calc_cur),
    .end_addr (calc_end),
    .chain    (calc_chain),
    .nxt_addr (calc_nxt),
    .bytes    (calc_bytes),
    .is_last  (calc_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      cur_q     <= '0;
      end_q     <= '0;
      chain_q   <= 1'b0;
      ent_valid <= 1'b0;
      ent_addr  <= '0;
      ent_bytes <= '0;
      ent_ur    <= CPL_OK;
      ent_last  <= 1'b0;
    end else begin
      ent_valid <= 1'b0;
      if (busy) begin
        ent_valid <= 1'b1;
        ent_addr  <= cur_q;
        ent_bytes <= calc_bytes;
        ent_ur    <= CPL_OK;
        ent_last  <= calc_last;
        cur_q     <= calc_nxt[AW-1:0];
        if (calc_last) busy <= 1'b0;
      end else if (accept) begin
        ent_valid <= 1'b1;
        unique case (kind)
          KIND_GOOD: begin
            ent_addr  <= req_addr;
            ent_bytes <= calc_bytes;
            ent_ur    <= CPL_OK;
            ent_last  <= calc_last;
            busy      <= !calc_last;
            cur_q     <= calc_nxt[AW-1:0];
            end_q     <= req_end;
            chain_q   <= req_chain;
          end
          KIND_NOTGT: begin
            ent_addr  <= REMAP;
            ent_bytes <= req_len;
            ent_ur    <= CPL_UR;
            ent_last  <= 1'b1;
          end
          default: begin
            ent_addr  <= req_addr;
            ent_bytes <= req_len;
            ent_ur    <= CPL_UR;
            ent_last  <= 1'b1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/rcs_checker.sv
module rcs_checker #(
  parameter int AW        = 32,
  parameter int LW        = 13,
  parameter int CHUNK_LOG = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic          ent_valid,
  input logic [AW-1:0] ent_addr,
  input logic [LW-1:0] ent_bytes,
  input logic          ent_ur,
  input logic          ent_last
);
  localparam logic [LW-1:0] MAX_CHUNK = LW'(2) << CHUNK_LOG;

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!ent_valid && req_ready));

  assert_accept_emits_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> ent_valid);

  assert_busy_blocks_R9: assert property (@(posedge clk) disable iff (rst)
    (ent_valid && !ent_last) |-> !req_ready);

  assert_final_frees_R5: assert property (@(posedge clk) disable iff (rst)
    (ent_valid && ent_last) |-> req_ready);

  // R2 and R3: consecutive entries abut
  assert_contiguous_R2: assert property (@(posedge clk) disable iff (rst)
    (ent_valid && !ent_last) |=>
      (ent_valid && ent_addr == $past(ent_addr) + AW'($past(ent_bytes))));

  assert_chunk_size_R4: assert property (@(posedge clk) disable iff (rst)
    (ent_valid && !ent_ur) |-> (ent_bytes != '0 && ent_bytes <= MAX_CHUNK));

  assert_ur_single_R7: assert property (@(posedge clk) disable iff (rst)
    (ent_valid && ent_ur) |-> ent_last);
endmodule

bind rd_cpl_splitter rcs_checker #(.AW(AW), .LW(LW), .CHUNK_LOG(CHUNK_LOG)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .ent_valid (ent_valid),
  .ent_addr  (ent_addr),
  .ent_bytes (ent_bytes),
  .ent_ur    (ent_ur),
  .ent_last  (ent_last)
);

// File: tb/sim_rd_cpl_splitter.sv
module sim_rd_cpl_splitter;
  localparam int AW = 32;
  localparam int LW = 13;
  localparam logic [31:0] REMAP = 32'h000C_0000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic          req_chain = 1'b0;
  logic [AW-1:0] tgt_addr;
  logic          tgt_hit = 1'b1;
  logic          ent_valid;
  logic [AW-1:0] ent_addr;
  logic [LW-1:0] ent_bytes;
  logic          ent_ur;
  logic          ent_last;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rd_cpl_splitter u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_chain(req_chain),
    .tgt_addr(tgt_addr), .tgt_hit(tgt_hit), .ent_valid(ent_valid),
    .ent_addr(ent_addr), .ent_bytes(ent_bytes), .ent_ur(ent_ur),
    .ent_last(ent_last)
  );

  task automatic chk(input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] a, input int len, input bit ch,
                       input bit hit, input string rq);
    @(negedge clk);
    chk(rq, "req_ready before request", longint'(req_ready), 1);
    req_valid = 1'b1; req_addr = a; req_len = LW'(len);
    req_chain = ch;   tgt_hit = hit;
    @(negedge clk);
    req_valid = 1'b0; tgt_hit = 1'b1;
  endtask

  // Good request: expected entries from chunk arithmetic (R2 R3 R4 R5 R6 R9)
  task automatic run_good(input logic [31:0] a, input int len, input bit ch,
                          input string rq);
    longint cs = ch ? 128 : 64;
    longint cur = longint'(a);
    longint fin = longint'(a) + len;
    longint sum = 0;
    bit lst = 1'b0;
    issue(a, len, ch, 1'b1, rq);
    while (!lst) begin
      longint b = (cur / cs + 1) * cs;
      longint n = (b < fin) ? b : fin;
      lst = (n == fin);
      chk(rq, "ent_valid", longint'(ent_valid), 1);
      chk(rq, "ent_addr", longint'(ent_addr), cur);
      chk(rq, "ent_bytes", longint'(ent_bytes), n - cur);
      chk("R6", "ent_ur", longint'(ent_ur), 0);
      chk("R5", "ent_last", longint'(ent_last), longint'(lst));
      chk("R9", "req_ready", longint'(req_ready), longint'(lst));
      sum += longint'(ent_bytes);
      cur = n;
      if (!lst) @(negedge clk);
    end
    chk("R4", "byte sum", sum, len);
    @(negedge clk);
    chk("R9", "ent_valid after last", longint'(ent_valid), 0);
  endtask

  // Single unsupported-request entry (R7 R8)
  task automatic run_single(input logic [31:0] a, input int len, input bit hit,
                            input logic [31:0] exp_addr, input string rq);
    issue(a, len, 1'b0, hit, rq);
    chk(rq, "ent_valid", longint'(ent_valid), 1);
    chk(rq, "ent_addr", longint'(ent_addr), longint'(exp_addr));
    chk(rq, "ent_bytes", longint'(ent_bytes), len);
    chk(rq, "ent_ur", longint'(ent_ur), 1);
    chk(rq, "ent_last", longint'(ent_last), 1);
    @(negedge clk);
    chk(rq, "no second entry", longint'(ent_valid), 0);
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    chk("R1", "ent_valid in reset", longint'(ent_valid), 0);
    chk("R1", "req_ready in reset", longint'(req_ready), 1);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "ent_valid after reset", longint'(ent_valid), 0);
    chk("R1", "req_ready after reset", longint'(req_ready), 1);
  endtask

  initial begin
    test_reset();
    run_good(32'h0000_1000, 256, 1'b0, "R2");
    run_good(32'h0000_1010, 200, 1'b0, "R2");
    run_good(32'h0000_1010, 200, 1'b1, "R3");
    run_good(32'h0000_2040, 64, 1'b1, "R3");
    run_good(32'h0000_2004, 8, 1'b0, "R4");
    run_good(32'h0000_20F0, 32, 1'b1, "R4");
    run_good(32'h0000_6FFF, 1, 1'b0, "R10");
    run_good(32'h0000_7F80, 128, 1'b0, "R10");
    run_good(32'h0000_5000, 4096, 1'b1, "R10");
    run_single(32'h0000_3010, 100, 1'b0, REMAP, "R7");
    run_single(32'h0000_3000, 0, 1'b1, 32'h0000_3000, "R8");
    run_single(32'h0000_3FF0, 32, 1'b1, 32'h0000_3FF0, "R8");
    run_single(32'h0000_3FC0, 65, 1'b0, 32'h0000_3FC0, "R8");
    run_good(32'h0000_8033, 70, 1'b0, "R6");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule